// File: doc/BRIEF.md
# Flash Block Protection State Manager

This block keeps the protection state of every erase block in a sectored flash array and rules on each program or erase request before the array sees it. Each block has a lock bit and a lock-down marker. Software changes them through a valid/ready command stream that carries an operation code and a block index. An active-low write-protect pin decides whether the lock-down marker has any effect. While write protect is asserted, a marked block is locked down and software cannot unlock it. While write protect is released, a marked block acts as an ordinary locked block that software may unlock and lock again. When write protect is asserted again, every marked block is forced back to locked-down.

Write requests arrive on a second valid/ready stream that carries a block index. One cycle after acceptance the block raises either a grant pulse or a protection-error pulse. A query port reports the effective state of any block and whether a write to it would be allowed. The active-low reset is also the power-down input. While it is low, the streams refuse traffic and every block reads as locked. Both ready outputs stay low for one further cycle after reset is released. Apart from those two windows, both readies are high, so back-pressure exists only around reset. A source must hold its request until it sees valid and ready high together at a rising clock edge.

Top module: `flash_lock_ctrl`

## Requirements
- R1: While rst_n is low, cmd_ready, wr_ready, wr_go and wr_err are 0, every block's lock bit is set and its marker is cleared, so every block queries as locked (01). Lock-down markers set before a reset do not survive it.
- R2: For the first clock cycle after rst_n rises, cmd_ready and wr_ready stay 0 and a command presented in that cycle has no effect. In every later cycle both are 1.
- R3: A command is taken at a rising edge where cmd_valid and cmd_ready are both 1, and it is visible on the query port after that edge. The cmd_op codes are 01 lock, 10 unlock, 11 lock-down (sets both the lock bit and the marker), and 00 no effect.
- R4: qry_state encodes 00 unlocked, 01 locked and 10 locked-down. A block reads locked-down when its marker is set and synchronized write protect is low. Otherwise it reads locked when its lock bit is set. qry_wr_ok is 1 only when qry_state is 00.
- R5: An unlock command to a block that reads locked-down leaves it locked-down.
- R6: While write protect is high, a marked block reads locked (01), and unlock and lock commands change it as they would an unmarked block. A lock-down command issued while write protect is high reads 01.
- R7: wr_prot_n passes through SYNC_STAGES flops. A change is visible on the query port after SYNC_STAGES rising edges and not after fewer. On a synchronized falling edge, the lock bit of every marked block is set. Such a block therefore reads locked-down, and reads locked again once write protect is released.
- R8: A write request is taken when wr_valid and wr_ready are both 1. After that edge, exactly one of wr_go and wr_err is 1 for exactly one cycle. wr_go is the one raised when the block read 00 in the acceptance cycle.
- R9: When a command and a write request target the same block in the same cycle, the write is judged on the state from before the command.
- R10: Lock and unlock commands never clear a lock-down marker. Only reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset / power-down |
| wr_prot_n | input | 1 | Asynchronous write protect; low enables lock-down |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_op | input | 2 | Operation code (01 lock, 10 unlock, 11 lock-down, 00 none) |
| cmd_blk | input | BLK_W | Block index for the command |
| wr_valid | input | 1 | Program/erase request valid |
| wr_ready | output | 1 | Program/erase stream ready |
| wr_blk | input | BLK_W | Block index for the program/erase request |
| wr_go | output | 1 | One-cycle grant pulse |
| wr_err | output | 1 | One-cycle protection-error pulse |
| qry_blk | input | BLK_W | Block index to query |
| qry_state | output | 2 | Effective state of the queried block |
| qry_wr_ok | output | 1 | Queried block may be written |

## Verification
The collision of interest is a protection command and a write request hitting the same block at the same rising edge. The test presents a lock command alongside a write to an unlocked block, then an unlock alongside a write to a locked block, from the same falling edge. It expects a grant in the first case and an error in the second, judged on the state that held before the edge. It then expects the query port to show the command's effect one edge later. A second case tests the write-protect revert against the marker. Software unlocks a marked block while protection is released. The test then checks that reasserting protection re-locks the block within the synchronizer delay and that the block stays locked after release.

// File: rtl/flk_pkg.sv
package flk_pkg;

  typedef enum logic [1:0] {
    LK_OP_NONE   = 2'b00,
    LK_OP_LOCK   = 2'b01,
    LK_OP_UNLOCK = 2'b10,
    LK_OP_DOWN   = 2'b11
  } lk_op_e;

  typedef enum logic [1:0] {
    ST_UNLOCKED = 2'b00,
    ST_LOCKED   = 2'b01,
    ST_DOWN     = 2'b10
  } lk_state_e;

  // Marker only counts while protection is active; then the lock bit.
  function automatic lk_state_e eff_state(input logic lock_b, input logic mark_b,
                                          input logic prot_on);
    if (mark_b && prot_on) return ST_DOWN;
    else if (lock_b)       return ST_LOCKED;
    else                   return ST_UNLOCKED;
  endfunction

endpackage

// File: rtl/flk_wp_sync.sv
module flk_wp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n_async,
  output logic wp_low,
  output logic wp_fall
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // Reset to "protected" so no spurious falling edge after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= wp_n_async;
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[STAGES-1];
    end
  end

  assign wp_low  = ~sync_q[STAGES-1];
  assign wp_fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/flk_lock_array.sv
module flk_lock_array
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_en,
  input  lk_op_e                cmd_op,
  input  logic [BLK_W-1:0]      cmd_blk,
  input  logic                  wp_low,
  input  logic                  wp_fall,
  output logic [NUM_BLOCKS-1:0] lock_q,
  output logic [NUM_BLOCKS-1:0] mark_q
);
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic hit;
    logic l_q;
    logic m_q;

    assign hit = cmd_en && (cmd_blk == BLK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_q <= 1'b1;
        m_q <= 1'b0;
      end else if (wp_fall && m_q) begin
        l_q <= 1'b1;                 // revert wins over any same-cycle command
      end else if (hit) begin
        case (cmd_op)
          LK_OP_LOCK:   l_q <= 1'b1;
          LK_OP_DOWN: begin
            l_q <= 1'b1;
            m_q <= 1'b1;
          end
          LK_OP_UNLOCK: if (!(m_q && wp_low)) l_q <= 1'b0;
          default: ;
        endcase
      end
    end

    assign lock_q[b] = l_q;
    assign mark_q[b] = m_q;
  end
endmodule

// File: rtl/flk_wr_gate.sv
module flk_wr_gate
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_fire,
  input  logic [BLK_W-1:0]      wr_blk,
  input  logic [BLK_W-1:0]      qry_blk,
  input  logic [NUM_BLOCKS-1:0] lock_q,
  input  logic [NUM_BLOCKS-1:0] mark_q,
  input  logic                  wp_low,
  output logic                  wr_go,
  output logic                  wr_err,
  output lk_state_e             qry_state
);
  lk_state_e wr_state;

  function automatic lk_state_e look(input logic [BLK_W-1:0] idx,
                                     input logic [NUM_BLOCKS-1:0] lk,
                                     input logic [NUM_BLOCKS-1:0] mk,
                                     input logic pl);
    if ({1'b0, idx} < (BLK_W+1)'(NUM_BLOCKS)) return eff_state(lk[idx], mk[idx], pl);
    else return ST_LOCKED;           // non-existent block: never writable
  endfunction

  always_comb begin
    wr_state  = look(wr_blk, lock_q, mark_q, wp_low);
    qry_state = look(qry_blk, lock_q, mark_q, wp_low);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_go  <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wr_go  <= wr_fire && (wr_state == ST_UNLOCKED);
      wr_err <= wr_fire && (wr_state != ST_UNLOCKED);
    end
  end
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_prot_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [BLK_W-1:0] wr_blk,
  output logic             wr_go,
  output logic             wr_err,
  input  logic [BLK_W-1:0] qry_blk,
  output logic [1:0]       qry_state,
  output logic             qry_wr_ok
);
  logic                  armed_q;
  logic                  wp_low;
  logic                  wp_fall;
  logic [NUM_BLOCKS-1:0] lock_q;
  logic [NUM_BLOCKS-1:0] mark_q;
  lk_state_e             q_state;

  // Requests are refused for one cycle after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign cmd_ready = armed_q;
  assign wr_ready  = armed_q;

  flk_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .wp_n_async(wr_prot_n),
    .wp_low(wp_low), .wp_fall(wp_fall)
  );

  flk_lock_array #(.NUM_BLOCKS(NUM_BLOCKS)) u_array (
    .clk(clk), .rst_n(rst_n),
    .cmd_en(cmd_valid && cmd_ready), .cmd_op(lk_op_e'(cmd_op)), .cmd_blk(cmd_blk),
    .wp_low(wp_low), .wp_fall(wp_fall),
    .lock_q(lock_q), .mark_q(mark_q)
  );

  flk_wr_gate #(.NUM_BLOCKS(NUM_BLOCKS)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_valid && wr_ready), .wr_blk(wr_blk), .qry_blk(qry_blk),
    .lock_q(lock_q), .mark_q(mark_q), .wp_low(wp_low),
    .wr_go(wr_go), .wr_err(wr_err), .qry_state(q_state)
  );

  assign qry_state = q_state;
  assign qry_wr_ok = (q_state == ST_UNLOCKED);
endmodule

// File: rtl/flk_chk.sv
module flk_chk
  import flk_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic                  cmd_ready,
  input logic [1:0]            cmd_op,
  input logic [BLK_W-1:0]      cmd_blk,
  input logic                  wr_valid,
  input logic                  wr_ready,
  input logic [BLK_W-1:0]      wr_blk,
  input logic                  wr_go,
  input logic                  wr_err,
  input logic [NUM_BLOCKS-1:0] lock_q,
  input logic [NUM_BLOCKS-1:0] mark_q,
  input logic                  wp_low,
  input logic                  wp_fall
);
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> ($countones({wr_go, wr_err}) == 1));

  assert_no_idle_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> (!wr_go && !wr_err));

  assert_grant_when_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !lock_q[wr_blk] && !(mark_q[wr_blk] && wp_low)) |=> wr_go);

  assert_unlock_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == LK_OP_UNLOCK && mark_q[cmd_blk] && wp_low)
      |=> lock_q[$past(cmd_blk)]);

  assert_marker_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mark_q) & ~mark_q) == '0);

  assert_revert_relocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_fall |=> ((lock_q & $past(mark_q)) == $past(mark_q)));
endmodule

bind flash_lock_ctrl flk_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_blk(wr_blk),
  .wr_go(wr_go), .wr_err(wr_err),
  .lock_q(lock_q), .mark_q(mark_q), .wp_low(wp_low), .wp_fall(wp_fall)
);

// File: tb/test_flash_lock_ctrl.sv
module test_flash_lock_ctrl;
  localparam int NB = 16;
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_prot_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'b00;
  logic [BW-1:0] cmd_blk = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [BW-1:0] wr_blk = '0;
  logic          wr_go, wr_err;
  logic [BW-1:0] qry_blk = '0;
  logic [1:0]    qry_state;
  logic          qry_wr_ok;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  flash_lock_ctrl #(.NUM_BLOCKS(NB), .SYNC_STAGES(2)) i_flash_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_prot_n(wr_prot_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_blk(wr_blk),
    .wr_go(wr_go), .wr_err(wr_err),
    .qry_blk(qry_blk), .qry_state(qry_state), .qry_wr_ok(qry_wr_ok)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_state(input string req, input int blk, input int st);
    qry_blk = BW'(blk);
    #1;
    check(req, qry_state, st);
    check(req, qry_wr_ok, st == 0);
  endtask

  task automatic send_cmd(input logic [1:0] op, input int blk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = BW'(blk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  task automatic send_wr(input string req, input int blk, input logic exp_go);
    @(negedge clk);
    wr_valid = 1'b1; wr_blk = BW'(blk);
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
    check(req, wr_go, exp_go);
    check(req, wr_err, !exp_go);
    @(negedge clk);
    #1;
    check(req, {wr_go, wr_err}, 0);
  endtask

  task automatic t_reset;
    #1;
    check("R1 cmd_ready in reset", cmd_ready, 0);
    check("R1 wr_ready in reset", wr_ready, 0);
    check("R1 pulses in reset", {wr_go, wr_err}, 0);
    expect_state("R1 block0 locked", 0, 1);
    expect_state("R1 block15 locked", 15, 1);
  endtask

  task automatic t_arm;
    @(negedge clk);
    rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_blk = BW'(3);
    #1;
    check("R2 cmd_ready first cycle", cmd_ready, 0);
    check("R2 wr_ready first cycle", wr_ready, 0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    expect_state("R2 early unlock ignored", 3, 1);
    check("R2 cmd_ready later", cmd_ready, 1);
    check("R2 wr_ready later", wr_ready, 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_basic;
    send_cmd(2'b10, 3);
    expect_state("R3 unlock", 3, 0);
    send_cmd(2'b01, 3);
    expect_state("R3 lock", 3, 1);
    send_cmd(2'b10, 4);
    send_cmd(2'b00, 4);
    expect_state("R3 no-op keeps unlocked", 4, 0);
    send_cmd(2'b10, 3);
    expect_state("R3 neighbour untouched", 5, 1);
  endtask

  task automatic t_write;
    send_wr("R8 grant unlocked", 3, 1'b1);
    send_wr("R8 refuse locked", 5, 1'b0);
  endtask

  task automatic t_lockdown;
    send_cmd(2'b11, 6);
    expect_state("R4 lock-down shows 10", 6, 2);
    send_cmd(2'b10, 6);
    expect_state("R5 unlock ignored", 6, 2);
    send_wr("R4 write refused when down", 6, 1'b0);
  endtask

  task automatic t_wp_cycle;
    @(negedge clk);
    wr_prot_n = 1'b1;
    @(negedge clk);
    expect_state("R7 one edge: still down", 6, 2);
    @(negedge clk);
    expect_state("R7 two edges: locked", 6, 1);
    send_cmd(2'b10, 6);
    expect_state("R6 unlock marked block", 6, 0);
    send_wr("R6 write after unlock", 6, 1'b1);
    send_cmd(2'b01, 6);
    expect_state("R6 relock marked block", 6, 1);
    send_cmd(2'b10, 6);
    send_cmd(2'b11, 7);
    expect_state("R6 lock-down while released", 7, 1);
    @(negedge clk);
    wr_prot_n = 1'b0;
    repeat (3) @(negedge clk);
    expect_state("R7 revert to down", 6, 2);
    expect_state("R10 marker kept after unlock", 7, 2);
    @(negedge clk);
    wr_prot_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_state("R7 locked after release", 6, 1);
  endtask

  task automatic t_collide;
    send_cmd(2'b10, 8);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_blk = BW'(8);
    wr_valid = 1'b1; wr_blk = BW'(8);
    @(negedge clk);
    cmd_valid = 1'b0; wr_valid = 1'b0;
    #1;
    check("R9 lock+write judged open", wr_go, 1);
    expect_state("R9 lock applied", 8, 1);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_blk = BW'(8);
    wr_valid = 1'b1; wr_blk = BW'(8);
    @(negedge clk);
    cmd_valid = 1'b0; wr_valid = 1'b0;
    #1;
    check("R9 unlock+write judged locked", wr_err, 1);
    expect_state("R9 unlock applied", 8, 0);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    wr_prot_n = 1'b0;
    rst_n = 1'b0;
    #1;
    expect_state("R1 reset relocks", 8, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_state("R1 markers cleared by reset", 6, 1);
    expect_state("R10 marker gone only via reset", 7, 1);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_arm();
    t_basic();
    t_write();
    t_lockdown();
    t_wp_cycle();
    t_collide();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule